// File: doc/BRIEF.md
# Super I/O Configuration Register Space

This block is the configuration side of a multi-function I/O controller. A host reaches it through two adjacent byte ports on the I/O bus. It first writes a register number to the lower port, the index port. It then reads or writes that register through the upper port, the data port. A strap input places the port pair at one of two fixed bus addresses.

The space holds a few global registers: a fixed identity byte, a chip-wide enable and a logical-unit selector. It also holds registers banked per logical unit: an activate bit and a 16-bit runtime base address. Each unit's activate bit and base address are brought out to the decoders of the runtime blocks. The GPIO unit has a pin selector. The selector picks one pin out of several 8-pin ports, and that pin's configuration byte and event byte are then reached through two further registers. All per-pin bytes are also brought out in parallel for the GPIO runtime logic.

Top module: `sio_cfg_space`

## Requirements
- R1: With `strap_alt`=0 the index port is at I/O address 0x002E, and with `strap_alt`=1 it is at 0x004E. The data port is always the index port address plus one. `io_hit` is 1 exactly when `io_addr` equals one of the two ports. A write to any other address changes no register.
- R2: The index register resets to 0x00. It keeps the last byte written to the index port, and a read of the index port returns that byte.
- R3: Index 0x20 reads as the parameter `CHIP_ID`. Writes to it have no effect.
- R4: Index 0x21 holds the chip enable in bit 0, which resets to 1. The other bits read 0. While the enable is 0, every bit of `unit_act_o` is 0. When it is set again, each stored activate bit shows again.
- R5: Index 0x07 is the unit selector. It resets to 0x00 and reads back all 8 bits as written.
- R6: Index 0x30 is the activate register of the selected unit. Bit 0 is stored, the other bits read 0, and it resets to 0. `unit_act_o[u]` carries unit u's bit.
- R7: Indices 0x60 and 0x61 hold the high and low bytes of the selected unit's base address. They reset to 0x0000, and `unit_base_o[16u+15:16u]` carries unit u's address.
- R8: When the selector holds a value of `NUM_UNITS` or more, indices 0x30, 0x60 and 0x61 read 0x00 and writes to them have no effect.
- R9: In the GPIO unit (`GPIO_UNIT`, default 7), index 0xF0 is the pin selector. Bits [7:4] give the port and bits [2:0] the bit, so pin n = 8*port + bit. Bit 3 is not stored and reads 0.
- R10: In the GPIO unit, index 0xF1 reads and writes the configuration byte of the selected pin, and 0xF2 its event byte. Both reset to 0x00 and appear on `pin_cfg_o[8n+7:8n]` and `pin_evt_o[8n+7:8n]`. If the selected port number is `NUM_PORTS` or more, both indices read 0x00 and writes to them have no effect.
- R11: In any unit other than the GPIO unit, indices 0xF0 to 0xF2 read 0x00 and writes to them have no effect.
- R12: Every other index reads 0x00, and writes to it have no effect.
- R13: `io_rdata` is 0x00 unless `io_rd` is 1 and `io_addr` hits a port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| strap_alt | input | 1 | 0: ports at 0x2E/0x2F; 1: ports at 0x4E/0x4F |
| io_addr | input | 16 | host I/O address |
| io_wr | input | 1 | host write strobe, one cycle per byte |
| io_rd | input | 1 | host read strobe |
| io_wdata | input | 8 | host write byte |
| io_rdata | output | 8 | host read byte, combinational |
| io_hit | output | 1 | address matches the index or data port |
| unit_act_o | output | NUM_UNITS | activate bit of each unit, gated by the chip enable |
| unit_base_o | output | 16*NUM_UNITS | runtime base address of each unit |
| pin_cfg_o | output | 8*NUM_PINS | configuration byte of each GPIO pin |
| pin_evt_o | output | 8*NUM_PINS | event byte of each GPIO pin |

## Verification
The bench aims at the places where banking can go wrong.

- It selects units above the implemented range. A design that wrapped the selector would then corrupt a low unit's base address.
- It touches the GPIO-only indices from other units. A design that missed this check would alter the pin bytes.
- It selects port numbers beyond the last port. A design without the bound would alias onto real pins.
- It writes a selector with bit 3 set. A design that let bit 3 through would address the wrong pin.

It also turns the chip enable off and on again, and a design that cleared the stored activate bits would lose them. Finally it moves the strap, and a decoder fixed to one address would still answer at the old port.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;
  localparam logic [7:0]  IDX_UNIT_SEL = 8'h07;
  localparam logic [7:0]  IDX_CHIP_ID  = 8'h20;
  localparam logic [7:0]  IDX_CHIP_CFG = 8'h21;
  localparam logic [7:0]  IDX_ACTIVATE = 8'h30;
  localparam logic [7:0]  IDX_BASE_HI  = 8'h60;
  localparam logic [7:0]  IDX_BASE_LO  = 8'h61;
  localparam logic [7:0]  IDX_PIN_SEL  = 8'hF0;
  localparam logic [7:0]  IDX_PIN_CFG  = 8'hF1;
  localparam logic [7:0]  IDX_PIN_EVT  = 8'hF2;
  localparam logic [15:0] PORT_PRIMARY   = 16'h002E;
  localparam logic [15:0] PORT_ALTERNATE = 16'h004E;
endpackage

// File: rtl/sio_port_decode.sv
module sio_port_decode
  import sio_cfg_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        strap_alt,
  input  logic [15:0] io_addr,
  input  logic        io_wr,
  input  logic [7:0]  io_wdata,
  output logic        idx_sel,
  output logic        dat_sel,
  output logic [7:0]  index_q
);
  logic [15:0] idx_port;
  logic        index_en;
  logic [7:0]  index_d;

  always_comb begin
    idx_port = strap_alt ? PORT_ALTERNATE : PORT_PRIMARY;
    idx_sel  = (io_addr == idx_port);
    dat_sel  = (io_addr == (idx_port + 16'd1));
  end

  always_comb begin
    index_en = io_wr & idx_sel;
    index_d  = io_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        index_q <= 8'h00;
    else if (index_en) index_q <= index_d;
  end
endmodule

// File: rtl/sio_unit_regs.sv
module sio_unit_regs
  import sio_cfg_pkg::*;
#(
  parameter int NUM_UNITS = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [7:0]              unit_sel,
  input  logic [7:0]              index,
  input  logic [7:0]              wdata,
  output logic [NUM_UNITS-1:0]    act_o,
  output logic [NUM_UNITS*16-1:0] base_o,
  output logic [7:0]              rd_data
);
  localparam int         UNIT_W     = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1;
  localparam logic [8:0] UNIT_LIMIT = 9'(NUM_UNITS);

  logic [NUM_UNITS-1:0] act_q;
  logic [15:0]          base_q [NUM_UNITS];
  logic                 sel_ok;
  logic [UNIT_W-1:0]    sel_idx;

  always_comb begin
    sel_ok  = ({1'b0, unit_sel} < UNIT_LIMIT);
    sel_idx = unit_sel[UNIT_W-1:0];
  end

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    logic       hit_u, act_en, hi_en, lo_en, act_d;
    logic [7:0] hi_d, lo_d, hi_q, lo_q;

    always_comb begin
      hit_u  = wr_en && (unit_sel == 8'(u));
      act_en = hit_u && (index == IDX_ACTIVATE);
      hi_en  = hit_u && (index == IDX_BASE_HI);
      lo_en  = hit_u && (index == IDX_BASE_LO);
      act_d  = wdata[0];
      hi_d   = wdata;
      lo_d   = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      act_q[u] <= 1'b0;
      else if (act_en) act_q[u] <= act_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     hi_q <= 8'h00;
      else if (hi_en) hi_q <= hi_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     lo_q <= 8'h00;
      else if (lo_en) lo_q <= lo_d;
    end

    assign base_q[u]          = {hi_q, lo_q};
    assign base_o[u*16 +: 16] = {hi_q, lo_q};
  end

  assign act_o = act_q;

  always_comb begin
    rd_data = 8'h00;
    if (sel_ok) begin
      case (index)
        IDX_ACTIVATE: rd_data = {7'b0, act_q[sel_idx]};
        IDX_BASE_HI:  rd_data = base_q[sel_idx][15:8];
        IDX_BASE_LO:  rd_data = base_q[sel_idx][7:0];
        default:      rd_data = 8'h00;
      endcase
    end
  end
endmodule

// File: rtl/sio_gpio_pins.sv
module sio_gpio_pins
  import sio_cfg_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  localparam int NUM_PINS = NUM_PORTS * 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [7:0]            index,
  input  logic [7:0]            wdata,
  output logic [NUM_PINS*8-1:0] cfg_o,
  output logic [NUM_PINS*8-1:0] evt_o,
  output logic [7:0]            rd_data
);
  localparam int         PORT_W     = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;
  localparam int         PIN_W      = PORT_W + 3;
  localparam logic [4:0] PORT_LIMIT = 5'(NUM_PORTS);

  logic             psel_en;
  logic [7:0]       psel_d, psel_q;
  logic             pin_ok;
  logic [PIN_W-1:0] pin_idx;
  logic [7:0]       cfg_arr [NUM_PINS];
  logic [7:0]       evt_arr [NUM_PINS];

  always_comb begin
    psel_en = wr_en && (index == IDX_PIN_SEL);
    psel_d  = {wdata[7:4], 1'b0, wdata[2:0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       psel_q <= 8'h00;
    else if (psel_en) psel_q <= psel_d;
  end

  always_comb begin
    pin_ok  = ({1'b0, psel_q[7:4]} < PORT_LIMIT);
    pin_idx = {psel_q[4 +: PORT_W], psel_q[2:0]};
  end

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    logic       hit_p, cfg_en, evt_en;
    logic [7:0] cfg_q, evt_q;

    always_comb begin
      hit_p  = wr_en && pin_ok && (pin_idx == PIN_W'(p));
      cfg_en = hit_p && (index == IDX_PIN_CFG);
      evt_en = hit_p && (index == IDX_PIN_EVT);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cfg_q <= 8'h00;
      else if (cfg_en) cfg_q <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      evt_q <= 8'h00;
      else if (evt_en) evt_q <= wdata;
    end

    assign cfg_arr[p]       = cfg_q;
    assign evt_arr[p]       = evt_q;
    assign cfg_o[p*8 +: 8]  = cfg_q;
    assign evt_o[p*8 +: 8]  = evt_q;
  end

  always_comb begin
    case (index)
      IDX_PIN_SEL: rd_data = psel_q;
      IDX_PIN_CFG: rd_data = pin_ok ? cfg_arr[pin_idx] : 8'h00;
      IDX_PIN_EVT: rd_data = pin_ok ? evt_arr[pin_idx] : 8'h00;
      default:     rd_data = 8'h00;
    endcase
  end
endmodule

// File: rtl/sio_cfg_space.sv
module sio_cfg_space
  import sio_cfg_pkg::*;
#(
  parameter logic [7:0] CHIP_ID   = 8'hE5,
  parameter int         NUM_UNITS = 16,
  parameter int         GPIO_UNIT = 7,
  parameter int         NUM_PORTS = 4,
  localparam int        NUM_PINS  = NUM_PORTS * 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    strap_alt,
  input  logic [15:0]             io_addr,
  input  logic                    io_wr,
  input  logic                    io_rd,
  input  logic [7:0]              io_wdata,
  output logic [7:0]              io_rdata,
  output logic                    io_hit,
  output logic [NUM_UNITS-1:0]    unit_act_o,
  output logic [NUM_UNITS*16-1:0] unit_base_o,
  output logic [NUM_PINS*8-1:0]   pin_cfg_o,
  output logic [NUM_PINS*8-1:0]   pin_evt_o
);
  logic                 idx_sel, dat_sel;
  logic [7:0]           index_q;
  logic                 data_wr;
  logic                 en_en, en_d, chip_en_q;
  logic                 sel_en;
  logic [7:0]           sel_d, unit_sel_q;
  logic                 gpio_sel, gpio_wr;
  logic [NUM_UNITS-1:0] act_raw;
  logic [7:0]           unit_rd, gpio_rd, reg_rd;

  sio_port_decode u_decode (
    .clk(clk), .rst_n(rst_n), .strap_alt(strap_alt), .io_addr(io_addr),
    .io_wr(io_wr), .io_wdata(io_wdata),
    .idx_sel(idx_sel), .dat_sel(dat_sel), .index_q(index_q)
  );

  always_comb begin
    data_wr  = io_wr & dat_sel;
    en_en    = data_wr && (index_q == IDX_CHIP_CFG);
    en_d     = io_wdata[0];
    sel_en   = data_wr && (index_q == IDX_UNIT_SEL);
    sel_d    = io_wdata;
    gpio_sel = (unit_sel_q == 8'(GPIO_UNIT));
    gpio_wr  = data_wr && gpio_sel;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     chip_en_q <= 1'b1;
    else if (en_en) chip_en_q <= en_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      unit_sel_q <= 8'h00;
    else if (sel_en) unit_sel_q <= sel_d;
  end

  sio_unit_regs #(.NUM_UNITS(NUM_UNITS)) u_units (
    .clk(clk), .rst_n(rst_n), .wr_en(data_wr), .unit_sel(unit_sel_q),
    .index(index_q), .wdata(io_wdata),
    .act_o(act_raw), .base_o(unit_base_o), .rd_data(unit_rd)
  );

  sio_gpio_pins #(.NUM_PORTS(NUM_PORTS)) u_gpio (
    .clk(clk), .rst_n(rst_n), .wr_en(gpio_wr), .index(index_q),
    .wdata(io_wdata), .cfg_o(pin_cfg_o), .evt_o(pin_evt_o), .rd_data(gpio_rd)
  );

  always_comb begin
    unit_act_o = act_raw & {NUM_UNITS{chip_en_q}};
    io_hit     = idx_sel | dat_sel;
  end

  always_comb begin
    case (index_q)
      IDX_UNIT_SEL:                          reg_rd = unit_sel_q;
      IDX_CHIP_ID:                           reg_rd = CHIP_ID;
      IDX_CHIP_CFG:                          reg_rd = {7'b0, chip_en_q};
      IDX_ACTIVATE, IDX_BASE_HI, IDX_BASE_LO: reg_rd = unit_rd;
      IDX_PIN_SEL, IDX_PIN_CFG, IDX_PIN_EVT: reg_rd = gpio_sel ? gpio_rd : 8'h00;
      default:                               reg_rd = 8'h00;
    endcase
  end

  always_comb begin
    if (!io_rd)       io_rdata = 8'h00;
    else if (idx_sel) io_rdata = index_q;
    else if (dat_sel) io_rdata = reg_rd;
    else              io_rdata = 8'h00;
  end
endmodule

// File: rtl/sio_cfg_space_chk.sv
module sio_cfg_space_chk #(
  parameter logic [7:0] CHIP_ID   = 8'hE5,
  parameter int         NUM_UNITS = 16,
  parameter int         NUM_PINS  = 32
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    strap_alt,
  input logic [15:0]             io_addr,
  input logic                    io_wr,
  input logic                    io_rd,
  input logic [7:0]              io_wdata,
  input logic [7:0]              io_rdata,
  input logic [NUM_UNITS-1:0]    unit_act_o,
  input logic [NUM_UNITS*16-1:0] unit_base_o,
  input logic [NUM_PINS*8-1:0]   pin_cfg_o,
  input logic [NUM_PINS*8-1:0]   pin_evt_o,
  input logic [7:0]              index_q
);
  logic [15:0] c_port;
  logic        c_idx, c_dat;

  always_comb begin
    c_port = strap_alt ? 16'h004E : 16'h002E;
    c_idx  = (io_addr == c_port);
    c_dat  = (io_addr == c_port + 16'd1);
  end

  a_r13_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !io_rd |-> io_rdata == 8'h00);

  a_r3_id_const: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && c_dat && index_q == 8'h20) |-> io_rdata == CHIP_ID);

  a_r2_index_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(io_wr && c_idx) |=> $stable(index_q));

  a_r4_disable_gates: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && c_dat && index_q == 8'h21 && !io_wdata[0]) |=> unit_act_o == '0);

  a_r1_miss_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && !c_idx && !c_dat) |=>
      ($stable(unit_base_o) && $stable(unit_act_o) && $stable(index_q)));

  a_r10_pins_need_write: assert property (@(posedge clk) disable iff (!rst_n)
    !io_wr |=> ($stable(pin_cfg_o) && $stable(pin_evt_o)));
endmodule

bind sio_cfg_space sio_cfg_space_chk #(
  .CHIP_ID(CHIP_ID), .NUM_UNITS(NUM_UNITS), .NUM_PINS(NUM_PINS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .strap_alt(strap_alt), .io_addr(io_addr),
  .io_wr(io_wr), .io_rd(io_rd), .io_wdata(io_wdata), .io_rdata(io_rdata),
  .unit_act_o(unit_act_o), .unit_base_o(unit_base_o),
  .pin_cfg_o(pin_cfg_o), .pin_evt_o(pin_evt_o), .index_q(index_q)
);

// File: tb/sio_cfg_space_bench.sv
`timescale 1ns/1ps
module sio_cfg_space_bench;
  localparam logic [7:0] CID = 8'hE5;
  localparam int NU = 16;
  localparam int GU = 7;
  localparam int NP = 4;
  localparam int NPIN = NP * 8;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic                strap_alt = 1'b0;
  logic [15:0]         io_addr = 16'h0;
  logic                io_wr = 1'b0;
  logic                io_rd = 1'b0;
  logic [7:0]          io_wdata = 8'h0;
  logic [7:0]          io_rdata;
  logic                io_hit;
  logic [NU-1:0]       unit_act_o;
  logic [NU*16-1:0]    unit_base_o;
  logic [NPIN*8-1:0]   pin_cfg_o, pin_evt_o;

  int checks = 0;
  int fails = 0;

  // bench model
  logic [7:0]  m_idx, m_sel, m_psel;
  logic        m_en;
  logic        m_act [NU];
  logic [15:0] m_base [NU];
  logic [7:0]  m_cfg [NPIN];
  logic [7:0]  m_evt [NPIN];
  logic [15:0] port;

  always #2 clk = ~clk;

  sio_cfg_space #(.CHIP_ID(CID), .NUM_UNITS(NU), .GPIO_UNIT(GU), .NUM_PORTS(NP)) u_sio_cfg_space (
    .clk(clk), .rst_n(rst_n), .strap_alt(strap_alt), .io_addr(io_addr),
    .io_wr(io_wr), .io_rd(io_rd), .io_wdata(io_wdata), .io_rdata(io_rdata),
    .io_hit(io_hit), .unit_act_o(unit_act_o), .unit_base_o(unit_base_o),
    .pin_cfg_o(pin_cfg_o), .pin_evt_o(pin_evt_o)
  );

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  function automatic int pin_of(input logic [7:0] ps);
    return int'(ps[7:4]) * 8 + int'(ps[2:0]);
  endfunction

  function automatic logic [7:0] exp_read();
    logic [7:0] r;
    r = 8'h00;
    case (m_idx)
      8'h07: r = m_sel;
      8'h20: r = CID;
      8'h21: r = {7'b0, m_en};
      8'h30: if (m_sel < NU) r = {7'b0, m_act[m_sel]};
      8'h60: if (m_sel < NU) r = m_base[m_sel][15:8];
      8'h61: if (m_sel < NU) r = m_base[m_sel][7:0];
      8'hF0: if (m_sel == GU) r = m_psel;
      8'hF1: if (m_sel == GU && m_psel[7:4] < NP) r = m_cfg[pin_of(m_psel)];
      8'hF2: if (m_sel == GU && m_psel[7:4] < NP) r = m_evt[pin_of(m_psel)];
      default: r = 8'h00;
    endcase
    return r;
  endfunction

  function automatic string tag_of(input logic [7:0] ix);
    case (ix)
      8'h07: return "R5";
      8'h20: return "R3";
      8'h21: return "R4";
      8'h30: return (m_sel < NU) ? "R6" : "R8";
      8'h60, 8'h61: return (m_sel < NU) ? "R7" : "R8";
      8'hF0: return (m_sel == GU) ? "R9" : "R11";
      8'hF1, 8'hF2: return (m_sel == GU) ? "R10" : "R11";
      default: return "R12";
    endcase
  endfunction

  function automatic void model_write(input logic [7:0] v);
    case (m_idx)
      8'h07: m_sel = v;
      8'h21: m_en = v[0];
      8'h30: if (m_sel < NU) m_act[m_sel] = v[0];
      8'h60: if (m_sel < NU) m_base[m_sel][15:8] = v;
      8'h61: if (m_sel < NU) m_base[m_sel][7:0] = v;
      8'hF0: if (m_sel == GU) m_psel = {v[7:4], 1'b0, v[2:0]};
      8'hF1: if (m_sel == GU && m_psel[7:4] < NP) m_cfg[pin_of(m_psel)] = v;
      8'hF2: if (m_sel == GU && m_psel[7:4] < NP) m_evt[pin_of(m_psel)] = v;
      default: ;
    endcase
  endfunction

  task automatic bus_wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_rd = 1'b1;
    #1 d = io_rdata;
    io_rd = 1'b0;
  endtask

  task automatic reg_wr(input logic [7:0] ix, input logic [7:0] v);
    bus_wr(port, ix); m_idx = ix;
    bus_wr(port + 16'd1, v); model_write(v);
  endtask

  task automatic reg_chk(input logic [7:0] ix);
    logic [7:0] d;
    bus_wr(port, ix); m_idx = ix;
    bus_rd(port + 16'd1, d);
    check(tag_of(ix), d, exp_read());
  endtask

  task automatic outs_chk(input string req);
    logic [NU-1:0] ea;
    logic [NU*16-1:0] eb;
    logic [NPIN*8-1:0] ec, ee;
    @(negedge clk);
    for (int u = 0; u < NU; u++) begin
      ea[u] = m_act[u] & m_en;
      eb[u*16 +: 16] = m_base[u];
    end
    for (int p = 0; p < NPIN; p++) begin
      ec[p*8 +: 8] = m_cfg[p];
      ee[p*8 +: 8] = m_evt[p];
    end
    check({req, " act"}, 64'(unit_act_o), 64'(ea));
    for (int k = 0; k < NU / 4; k++) check({req, " base"}, unit_base_o[k*64 +: 64], eb[k*64 +: 64]);
    for (int k = 0; k < NPIN / 8; k++) begin
      check({req, " cfg"}, pin_cfg_o[k*64 +: 64], ec[k*64 +: 64]);
      check({req, " evt"}, pin_evt_o[k*64 +: 64], ee[k*64 +: 64]);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    logic [7:0] d;
    logic [7:0] ixs [12];
    void'($urandom(32'd20240611));
    ixs = '{8'h07, 8'h20, 8'h21, 8'h30, 8'h60, 8'h61, 8'hF0, 8'hF1, 8'hF2, 8'h55, 8'h22, 8'h31};
    port = 16'h002E;
    m_idx = 0; m_sel = 0; m_psel = 0; m_en = 1'b1;
    for (int u = 0; u < NU; u++) begin m_act[u] = 0; m_base[u] = 0; end
    for (int p = 0; p < NPIN; p++) begin m_cfg[p] = 0; m_evt[p] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // reset state
    check("R13 idle", io_rdata, 8'h00);
    bus_rd(16'h002E, d); check("R2 reset index", d, 8'h00);
    outs_chk("R6 R7 R10 reset");
    reg_chk(8'h07); reg_chk(8'h21); reg_chk(8'h20);

    // R3: id is read-only
    reg_wr(8'h20, 8'h00); reg_chk(8'h20);
    // R2: index reads back
    bus_wr(16'h002E, 8'hA7); bus_rd(16'h002E, d); check("R2 index readback", d, 8'hA7);

    // R7 R6: banked base and activate in unit 0x0D
    reg_wr(8'h07, 8'h0D); reg_wr(8'h60, 8'h12); reg_wr(8'h61, 8'h34); reg_wr(8'h30, 8'hFF);
    reg_chk(8'h30); reg_chk(8'h60); reg_chk(8'h61);
    check("R7 base out", unit_base_o[13*16 +: 16], 16'h1234);
    check("R6 act out", unit_act_o, 16'h2000);
    // R11: GPIO indices in another unit
    reg_wr(8'hF0, 8'h15); reg_wr(8'hF1, 8'h77); reg_chk(8'hF0); reg_chk(8'hF1);
    outs_chk("R11 no effect");

    // R8: unit beyond range
    reg_wr(8'h07, 8'h1D); reg_wr(8'h60, 8'hEE); reg_wr(8'h30, 8'h01);
    reg_chk(8'h60); reg_chk(8'h30); outs_chk("R8 no alias");

    // R9 R10: pin 13 = port 1 bit 5 -> selector 0x15
    reg_wr(8'h07, 8'h07); reg_wr(8'hF0, 8'h15); reg_wr(8'hF1, 8'hA5); reg_wr(8'hF2, 8'h3C);
    check("R10 pin13 cfg", pin_cfg_o[13*8 +: 8], 8'hA5);
    check("R10 pin13 evt", pin_evt_o[13*8 +: 8], 8'h3C);
    reg_wr(8'hF0, 8'h3F); bus_wr(port, 8'hF0); bus_rd(port + 16'd1, d); check("R9 bit3 dropped", d, 8'h37);
    reg_wr(8'hF1, 8'h5A); check("R10 pin31 cfg", pin_cfg_o[31*8 +: 8], 8'h5A);
    reg_wr(8'hF0, 8'h42); reg_wr(8'hF1, 8'h99); reg_chk(8'hF1); outs_chk("R10 port bound");

    // R4: chip enable gating
    reg_wr(8'h21, 8'hFE); reg_chk(8'h21); check("R4 gated", unit_act_o, 16'h0000);
    reg_wr(8'h21, 8'h01); check("R4 restored", unit_act_o, 16'h2000);

    // R12: unimplemented index
    reg_wr(8'h55, 8'hFF); reg_chk(8'h55); outs_chk("R12 no effect");

    // random phase
    for (int n = 0; n < 1500; n++) begin
      logic [7:0] ix, v;
      ix = ixs[$urandom_range(0, 11)];
      v = 8'($urandom);
      if (ix == 8'h07) v = ($urandom_range(0, 3) == 0) ? 8'd7 : 8'($urandom_range(0, 19));
      if (ix == 8'hF0 && $urandom_range(0, 3) != 0) v = v & 8'h3F;
      if ($urandom_range(0, 1) == 0) reg_wr(ix, v);
      else reg_chk(ix);
    end
    outs_chk("R6 R7 R10 random");

    // R1: alternate strap
    @(negedge clk); strap_alt = 1'b1; port = 16'h004E;
    io_addr = 16'h002E; #1 check("R1 old port miss", io_hit, 1'b0);
    io_addr = 16'h004F; #1 check("R1 new data hit", io_hit, 1'b1);
    bus_wr(16'h002E, 8'h07); bus_wr(16'h002F, 8'h03);
    bus_rd(16'h002F, d); check("R1 miss reads zero", d, 8'h00);
    reg_chk(8'h07);
    reg_wr(8'h07, 8'h02); reg_wr(8'h61, 8'hC3); reg_chk(8'h61);
    bus_wr(16'h1234, 8'h55); outs_chk("R1 strap alt");
    io_addr = 16'h004F; #1 check("R13 no strobe", io_rdata, 8'h00);

    summary();
  end
endmodule